// File: doc/BRIEF.md
# Board interrupt and status controller

This block gathers sixteen external level-sensitive interrupt lines for a host processor. Each line passes through a two-stage synchroniser. While its enable bit is set, a high line sets a pending bit. A single interrupt output is raised whenever any pending bit is also enabled. Software reads the pending word to find the cause. It clears a cause by writing the pending word with that bit at zero, so the word is written directly rather than cleared by writing ones. The enable and pending words only keep the bits selected by the write mask 0x000F_EEFF.

The block also holds eight 32-bit general scratch and control registers and two card-slot status registers. Each slot register carries a ready flag, an active-low card-present flag driven by a dedicated interrupt line, and a five-bit control field that software may write. Access is through a plain synchronous register port: one byte address, a write strobe, a read strobe, write data and registered read data. The port accepts every access in the cycle it is presented, so it has no handshake and never applies back-pressure. Read data appears on the cycle after the read strobe and is held until the next read.

Top module: `brd_irq_ctl`

## Requirements
- R1: After reset the enable word, the pending word and all eight scratch registers read 0, both slot registers read 0x0000_0420, and the interrupt output is low.
- R2: A synchronised high line whose enable bit is set sets its pending bit. A line that is high only while its enable bit is clear leaves its pending bit at 0, even if the bit is enabled after the line has fallen.
- R3: The interrupt output is high exactly when the bitwise AND of the pending and enable words is non-zero, including directly after a write to either word.
- R4: Writes to the enable word (address 0xC0) and the pending word (address 0xD0) store the data ANDed with 0x000F_EEFF. Writing 0 to a pending bit clears it, and writing 1 sets it.
- R5: When a latching line and a bus write to the pending word fall in the same cycle, the bit set by the line wins.
- R6: Bit 5 of slot register 0 (address 0xE0) is the inverse of synchronised line 9. Bit 5 of slot register 1 (address 0xE4) is the inverse of synchronised line 13.
- R7: A write to a slot register changes only bits 4:0. Bit 10 stays at 1 and all other bits keep their values.
- R8: Addresses 0x10, 0x14, 0x40, 0x60, 0x80, 0x84, 0x88 and 0x90 are 32-bit read/write registers with no side effects.
- R9: A read from any other address returns 0, and a write to any other address changes no register.
- R10: Read data is valid on the cycle after the read strobe and holds its value while no read is requested.
- R11: A line that rises just before clock edge 1 reaches its pending bit, and the interrupt output, at edge 3 and not earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | 8 | Byte address, word aligned |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| irq_in | input | 16 | External interrupt lines, active high level |
| irq_out | output | 1 | Combined interrupt to the host |

## Verification
The hardest case to reach from the ports is a collision: a pending-word write that clears a bit in the same cycle that the still-high, enabled line sets it again. A second hard case is a line that was high only while disabled and must leave no trace once enabled later. Directed sequences hold a line high across a clearing write, and raise and drop a line before its enable is written. The exact three-edge latency is checked by sampling the output between the individual edges. Random traffic then mixes writes to every address, mapped or not, with random line patterns, and checks each read against a bench model.

// File: rtl/brd_irq_pkg.sv
package brd_irq_pkg;
  localparam int DW     = 32;
  localparam int AW     = 8;
  localparam int N_IRQ  = 16;
  localparam int N_SCR  = 8;
  localparam int CTL_W  = 5;
  localparam int CD_BIT = 5;
  localparam int RDY_BIT = 10;
  localparam int CD_SRC0 = 9;
  localparam int CD_SRC1 = 13;

  localparam logic [DW-1:0] IRQ_WMASK = 32'h000F_EEFF;

  localparam logic [AW-1:0] A_EN    = 8'hC0;
  localparam logic [AW-1:0] A_PEND  = 8'hD0;
  localparam logic [AW-1:0] A_SLOT0 = 8'hE0;
  localparam logic [AW-1:0] A_SLOT1 = 8'hE4;

  // Address of scratch register i
  function automatic logic [AW-1:0] scr_addr(input int i);
    case (i)
      0:       return 8'h10;
      1:       return 8'h14;
      2:       return 8'h40;
      3:       return 8'h60;
      4:       return 8'h80;
      5:       return 8'h84;
      6:       return 8'h88;
      default: return 8'h90;
    endcase
  endfunction

  function automatic logic is_mapped(input logic [AW-1:0] a);
    logic hit;
    hit = (a == A_EN) || (a == A_PEND) || (a == A_SLOT0) || (a == A_SLOT1);
    for (int i = 0; i < N_SCR; i++) begin
      if (a == scr_addr(i)) hit = 1'b1;
    end
    return hit;
  endfunction
endpackage

// File: rtl/brd_irq_sync.sv
module brd_irq_sync #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta <= '0;
      q    <= '0;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/brd_irq_core.sv
module brd_irq_core #(
  parameter int              DW    = 32,
  parameter int              N_IRQ = 16,
  parameter logic [DW-1:0]   WMASK = 32'h000F_EEFF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_IRQ-1:0] lvl,
  input  logic             en_we,
  input  logic             pend_we,
  input  logic [DW-1:0]    wdata,
  output logic [DW-1:0]    en_q,
  output logic [DW-1:0]    pend_q,
  output logic             irq_out
);
  localparam int PAD = DW - N_IRQ;

  logic [DW-1:0] lvl_ext;
  logic [DW-1:0] pend_base;
  logic [DW-1:0] pend_d;

  assign lvl_ext = {{PAD{1'b0}}, lvl};

  // Bus write forms the base; line sets are ORed on top (line wins)
  always_comb begin
    pend_base = pend_we ? (wdata & WMASK) : pend_q;
    pend_d    = pend_base | (lvl_ext & en_q & WMASK);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= '0;
      pend_q <= '0;
    end else begin
      pend_q <= pend_d;
      if (en_we) en_q <= wdata & WMASK;
    end
  end

  assign irq_out = |(pend_q & en_q);
endmodule

// File: rtl/brd_slot_reg.sv
module brd_slot_reg #(
  parameter int DW      = 32,
  parameter int CTL_W   = 5,
  parameter int CD_BIT  = 5,
  parameter int RDY_BIT = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [CTL_W-1:0] wdata,
  input  logic             cd_lvl,
  output logic [DW-1:0]    rd_val
);
  logic [CTL_W-1:0] ctl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  ctl_q <= '0;
    else if (we) ctl_q <= wdata;
  end

  always_comb begin
    rd_val              = '0;
    rd_val[CTL_W-1:0]   = ctl_q;
    rd_val[CD_BIT]      = ~cd_lvl;
    rd_val[RDY_BIT]     = 1'b1;
  end
endmodule

// File: rtl/brd_scratch.sv
module brd_scratch #(
  parameter int DW = 32,
  parameter int AW = 8,
  parameter int N  = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic          hit,
  output logic [DW-1:0] rd_val
);
  import brd_irq_pkg::*;

  logic [N-1:0]  sel;
  logic [DW-1:0] regs [N];

  for (genvar g = 0; g < N; g++) begin : g_reg
    assign sel[g] = (addr == scr_addr(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           regs[g] <= '0;
      else if (we && sel[g]) regs[g] <= wdata;
    end
  end

  assign hit = |sel;

  always_comb begin
    rd_val = '0;
    for (int i = 0; i < N; i++) begin
      if (sel[i]) rd_val = regs[i];
    end
  end
endmodule

// File: rtl/brd_irq_ctl.sv
module brd_irq_ctl
  import brd_irq_pkg::*;
#(
  parameter int DW    = brd_irq_pkg::DW,
  parameter int AW    = brd_irq_pkg::AW,
  parameter int N_IRQ = brd_irq_pkg::N_IRQ
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [AW-1:0]    bus_addr,
  input  logic             bus_wr,
  input  logic             bus_rd,
  input  logic [DW-1:0]    bus_wdata,
  output logic [DW-1:0]    bus_rdata,
  input  logic [N_IRQ-1:0] irq_in,
  output logic             irq_out
);
  localparam int N_SLOT = 2;

  logic [N_IRQ-1:0] lvl_s;
  logic [DW-1:0]    en_q, pend_q;
  logic             scr_hit;
  logic [DW-1:0]    scr_val;
  logic [DW-1:0]    slot_val [N_SLOT];
  logic [N_SLOT-1:0] slot_sel;
  logic [DW-1:0]    rd_mux;

  brd_irq_sync #(.W(N_IRQ)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(irq_in), .q(lvl_s)
  );

  brd_irq_core #(.DW(DW), .N_IRQ(N_IRQ), .WMASK(IRQ_WMASK)) u_core (
    .clk(clk), .rst_n(rst_n), .lvl(lvl_s),
    .en_we(bus_wr && bus_addr == A_EN),
    .pend_we(bus_wr && bus_addr == A_PEND),
    .wdata(bus_wdata), .en_q(en_q), .pend_q(pend_q), .irq_out(irq_out)
  );

  brd_scratch #(.DW(DW), .AW(AW), .N(N_SCR)) u_scr (
    .clk(clk), .rst_n(rst_n), .we(bus_wr), .addr(bus_addr),
    .wdata(bus_wdata), .hit(scr_hit), .rd_val(scr_val)
  );

  for (genvar s = 0; s < N_SLOT; s++) begin : g_slot
    localparam logic [AW-1:0] SA  = (s == 0) ? A_SLOT0 : A_SLOT1;
    localparam int            SRC = (s == 0) ? CD_SRC0 : CD_SRC1;
    assign slot_sel[s] = (bus_addr == SA);
    brd_slot_reg #(.DW(DW), .CTL_W(CTL_W), .CD_BIT(CD_BIT), .RDY_BIT(RDY_BIT)) u_slot (
      .clk(clk), .rst_n(rst_n), .we(bus_wr && slot_sel[s]),
      .wdata(bus_wdata[CTL_W-1:0]), .cd_lvl(lvl_s[SRC]), .rd_val(slot_val[s])
    );
  end

  always_comb begin
    rd_mux = '0;
    if (scr_hit)                rd_mux = scr_val;
    else if (bus_addr == A_EN)   rd_mux = en_q;
    else if (bus_addr == A_PEND) rd_mux = pend_q;
    else if (slot_sel[0])        rd_mux = slot_val[0];
    else if (slot_sel[1])        rd_mux = slot_val[1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_mux;
  end
endmodule

// File: rtl/brd_irq_chk.sv
module brd_irq_chk
  import brd_irq_pkg::*;
#(
  parameter int DW    = brd_irq_pkg::DW,
  parameter int AW    = brd_irq_pkg::AW,
  parameter int N_IRQ = brd_irq_pkg::N_IRQ
) (
  input logic             clk,
  input logic             rst_n,
  input logic [AW-1:0]    bus_addr,
  input logic             bus_wr,
  input logic             bus_rd,
  input logic [DW-1:0]    bus_rdata,
  input logic [N_IRQ-1:0] lvl,
  input logic [DW-1:0]    en_q,
  input logic [DW-1:0]    pend_q
);
  logic [DW-1:0] set_now;
  assign set_now = {{(DW-N_IRQ){1'b0}}, lvl} & en_q;

  // R2 and R5: an enabled high line is pending on the next edge, whatever the bus did
  p_latch_r5: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((pend_q & $past(set_now)) == $past(set_now)));

  // R2: without a pending-word write, a new pending bit needs an enabled high line
  p_noset_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_wr && bus_addr == A_PEND) |=> ((pend_q & ~$past(pend_q) & ~$past(set_now)) == '0));

  // R4: masked-off bits never hold a one
  p_mask_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ((pend_q | en_q) & ~IRQ_WMASK) == '0);

  // R9: unmapped reads return zero
  p_unmapped_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && !is_mapped(bus_addr)) |=> (bus_rdata == '0));

  // R10: read data holds with no read request
  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |=> $stable(bus_rdata));

  // R6: card-present flag of slot 0 is the inverse of line 9
  p_cd0_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == A_SLOT0) |=> (bus_rdata[CD_BIT] == !$past(lvl[CD_SRC0])));

  // R7: ready flag always reads one
  p_rdy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && (bus_addr == A_SLOT0 || bus_addr == A_SLOT1)) |=> bus_rdata[RDY_BIT]);
endmodule

bind brd_irq_ctl brd_irq_chk #(.DW(DW), .AW(AW), .N_IRQ(N_IRQ)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
  .bus_rdata(bus_rdata), .lvl(lvl_s), .en_q(en_q), .pend_q(pend_q)
);

// File: tb/test_brd_irq_ctl.sv
`timescale 1ns/1ps
module test_brd_irq_ctl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [15:0] irq_in = '0;
  logic        irq_out;

  int errors = 0;
  int checks = 0;

  localparam logic [31:0] M = 32'h000F_EEFF;
  localparam logic [7:0] SCR_A [8] = '{8'h10, 8'h14, 8'h40, 8'h60, 8'h80, 8'h84, 8'h88, 8'h90};
  localparam logic [7:0] POOL [16] = '{8'h10, 8'h14, 8'h40, 8'h60, 8'h80, 8'h84, 8'h88, 8'h90,
                                       8'hC0, 8'hD0, 8'hE0, 8'hE4, 8'h00, 8'h44, 8'hFC, 8'hD4};

  // bench model
  logic [31:0] m_scr [8];
  logic [31:0] m_en = '0, m_pend = '0;
  logic [4:0]  m_ctl0 = '0, m_ctl1 = '0;
  logic [15:0] m_lvl = '0;

  always #2.5 clk = ~clk;

  brd_irq_ctl i_brd_irq_ctl (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_in(irq_in), .irq_out(irq_out)
  );

  function automatic logic [31:0] exp_read(input logic [7:0] a);
    for (int i = 0; i < 8; i++) if (a == SCR_A[i]) return m_scr[i];
    case (a)
      8'hC0: return m_en;
      8'hD0: return m_pend;
      8'hE0: return 32'h400 | (m_lvl[9]  ? 32'h0 : 32'h20) | {27'b0, m_ctl0};
      8'hE4: return 32'h400 | (m_lvl[13] ? 32'h0 : 32'h20) | {27'b0, m_ctl1};
      default: return 32'h0;
    endcase
  endfunction

  function automatic logic exp_irq();
    return |(m_pend & m_en);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic settle();
    m_pend = m_pend | ({16'b0, m_lvl} & m_en);
  endtask

  task automatic do_write(input logic [7:0] a, input logic [31:0] d, input string req);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
    @(negedge clk);
    for (int i = 0; i < 8; i++) if (a == SCR_A[i]) m_scr[i] = d;
    case (a)
      8'hC0: m_en = d & M;
      8'hD0: m_pend = (d & M) | ({16'b0, m_lvl} & m_en);
      8'hE0: m_ctl0 = d[4:0];
      8'hE4: m_ctl1 = d[4:0];
      default: ;
    endcase
    settle();
    chk({req, " irq_out (R3)"}, {31'b0, irq_out}, {31'b0, exp_irq()});
  endtask

  task automatic do_read(input logic [7:0] a, input string req);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    chk(req, bus_rdata, exp_read(a));
  endtask

  task automatic set_lines(input logic [15:0] v, input string req);
    @(negedge clk);
    irq_in = v;
    repeat (4) @(negedge clk);
    m_lvl = v;
    settle();
    chk({req, " irq_out (R3)"}, {31'b0, irq_out}, {31'b0, exp_irq()});
  endtask

  initial begin
    #900000;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] held;
    for (int i = 0; i < 8; i++) m_scr[i] = '0;
    void'($urandom(32'h1357_9BDF));
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 irq_out at reset", {31'b0, irq_out}, 32'h0);
    do_read(8'hE0, "R1 slot0 reset");
    do_read(8'hE4, "R1 slot1 reset");
    do_read(8'hC0, "R1 enable reset");
    do_read(8'hD0, "R1 pending reset");
    for (int i = 0; i < 8; i++) do_read(SCR_A[i], "R1 scratch reset");

    // R11 three-edge latency on line 0
    do_write(8'hC0, 32'h1, "R11 setup");
    @(negedge clk);
    irq_in = 16'h0001;
    @(posedge clk); @(posedge clk); #1;
    chk("R11 irq_out after two edges", {31'b0, irq_out}, 32'h0);
    @(posedge clk); #1;
    chk("R11 irq_out after three edges", {31'b0, irq_out}, 32'h1);
    m_lvl = 16'h0001; settle();
    do_read(8'hD0, "R11 pending bit0");

    // R2 a line high only while disabled leaves no trace
    set_lines(16'h0011, "R2 line4 high disabled");
    do_read(8'hD0, "R2 pending without enable");
    set_lines(16'h0001, "R2 line4 low");
    do_write(8'hC0, 32'h11, "R2 enable line4 late");
    do_read(8'hD0, "R2 pending after late enable");

    // R4 write masking and direct pending write
    do_write(8'hC0, 32'hFFFF_FFFF, "R4 enable all");
    do_read(8'hC0, "R4 enable masked");
    do_write(8'hD0, 32'hFFFF_FFFF, "R4 pending all");
    do_read(8'hD0, "R4 pending masked");
    set_lines(16'h0000, "R4 lines low");
    do_write(8'hD0, 32'h0000_0000, "R4 clear by zero");
    do_read(8'hD0, "R4 pending cleared");
    do_write(8'hD0, 32'h0000_0040, "R4 set by one");
    do_read(8'hD0, "R4 pending set by write");

    // R5 line set beats clearing write
    set_lines(16'h0008, "R5 line3 high");
    do_write(8'hD0, 32'h0, "R5 clear collides");
    do_read(8'hD0, "R5 pending kept by line");

    // R3 output drops when enable cleared
    do_write(8'hC0, 32'h0, "R3 disable all");
    chk("R3 irq_out low with pending set", {31'b0, irq_out}, 32'h0);

    // R6 card-present bits
    set_lines(16'h0200, "R6 line9 high");
    do_read(8'hE0, "R6 slot0 card present");
    do_read(8'hE4, "R6 slot1 unaffected");
    set_lines(16'h2000, "R6 line13 high");
    do_read(8'hE0, "R6 slot0 card gone");
    do_read(8'hE4, "R6 slot1 card present");

    // R7 slot writes touch bits 4:0 only
    do_write(8'hE0, 32'hFFFF_FFFF, "R7 slot0 all ones");
    do_read(8'hE0, "R7 slot0 after write");
    do_write(8'hE4, 32'h0000_0015, "R7 slot1 pattern");
    do_read(8'hE4, "R7 slot1 after write");

    // R8 scratch registers
    for (int i = 0; i < 8; i++) do_write(SCR_A[i], 32'hA5A5_0000 + i, "R8 scratch write");
    for (int i = 0; i < 8; i++) do_read(SCR_A[i], "R8 scratch read");

    // R9 unmapped access
    do_write(8'h44, 32'hDEAD_BEEF, "R9 unmapped write");
    do_read(8'h44, "R9 unmapped read");
    do_read(8'h40, "R9 neighbour untouched");
    do_read(8'h12, "R9 misaligned read");

    // R10 read data holds without read
    do_read(8'h10, "R10 read");
    held = bus_rdata;
    @(negedge clk); bus_addr = 8'h14;
    repeat (3) @(negedge clk);
    chk("R10 rdata held", bus_rdata, held);

    // random mix
    for (int n = 0; n < 400; n++) begin
      int op;
      logic [7:0] a;
      op = int'($urandom_range(0, 9));
      a = POOL[$urandom_range(0, 15)];
      if (op < 4)      do_write(a, $urandom(), "R8 random write");
      else if (op < 8) do_read(a, "R9 random read");
      else             set_lines(16'($urandom()), "R2 random lines");
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule